// File: doc/BRIEF.md
# Receive Buffer Area Sequencer

This block tracks where received packets land inside a ring of receive buffer areas. Each buffer area is described by a resource descriptor held in a ring in memory. The block asks for the next descriptor, loads that area's word budget, and subtracts each completed packet's word count from the budget. After every packet it compares the words left against a programmable end-of-area threshold. If enough room remains, the next packet stays in the same area. If not, the packet is flagged as the last one in its area and the block goes to fetch a fresh descriptor.

Two linked modulo-256 counters sit alongside the area decision. One counts packets within the current area. The other counts areas consumed. Their values at the moment a packet completes are published, together with the last-in-area flag, as a one-cycle status pulse. A small register write port programs the threshold, the counters, the upper resource address byte and the four ring pointers (start, end, read, write). The block turns the read pointer into a 23-bit fetch address and the write pointer into a 23-bit free-slot address.

The controller has three states. `ST_NEED_DESC` waits for the ring to hold an unread descriptor and holds `exhausted` high while the ring is empty. `ST_FETCH_DESC` holds `fetch_req` until `fetch_ack` arrives. `ST_FILL_AREA` accepts packets into the loaded area. The transitions are as follows. NEED→FETCH happens when the read pointer differs from the write pointer. FETCH→FILL happens on `fetch_ack`. FILL→NEED happens on a packet whose remainder falls below the threshold. `soft_rst` sends any state to NEED.

Top module: `rba_sequencer`

## Requirements
- R1: After hardware reset the end-of-area threshold is 760 (0x02F8) words, the status word is 0x0000, `status_valid` is 0, and the controller is in the need-descriptor state.
- R2: When a packet completes and the threshold is less than or equal to the words remaining after that packet, `last_pkt` is 0 and the packet number (status bits 7:0) increments for the next packet.
- R3: When a packet completes and the threshold is greater than the words remaining, `last_pkt` is 1 and the next accepted packet reports packet number 0 with the area number (status bits 15:8) incremented. A new descriptor is requested before any further packet is accepted.
- R4: `status_valid` pulses for exactly the cycle after an accepted `pkt_done`. `seq_status` and `last_pkt` then carry that packet's area and packet numbers as they were before that packet's update.
- R5: Both 8-bit numbers wrap modulo 256. The packet number rolls from 0xFF to 0x00 without touching the area number, and the area number rolls from 0xFF to 0x00.
- R6: A register write to select 1 loads both counters from `reg_wdata` (so zero clears them). If a packet completes in the same cycle, that packet reports the old values and the written value wins over the increment.
- R7: `soft_rst` returns the controller to need-descriptor and discards the current area's budget. It leaves the threshold, the counters and the ring pointers unchanged.
- R8: While fetching, `fetch_req` stays high until `fetch_ack`. `fetch_addr` equals {upper byte, read index}, and the area budget is loaded from `fetch_words` on the acknowledge.
- R9: After each descriptor fetch the read index advances by 4 words. If it then equals the end index, it is set to the start index.
- R10: In the need-descriptor state with read index equal to write index, `exhausted` is 1 and `fetch_req` stays 0. Writing a different write index resumes fetching.
- R11: A `pkt_done` while no area is loaded produces no status pulse and leaves the counters unchanged.
- R12: If a packet's word count exceeds the words remaining, the remainder is taken as 0, not a wrapped value.
- R13: `free_addr` equals {upper byte, write index}. Pointer registers take `reg_wdata[15:1]` as the word index, and bit 0 is dropped. Register selects are: 0 threshold, 1 counters, 2 upper byte, 3 start, 4 end, 5 read, 6 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| soft_rst | input | 1 | Software reset of the area controller |
| pkt_done | input | 1 | One-cycle strobe at packet completion |
| pkt_words | input | 16 | Word count of the completed packet |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| fetch_req | output | 1 | Request to read the next resource descriptor |
| fetch_addr | output | 23 | Word address of that descriptor |
| fetch_ack | input | 1 | Descriptor read complete |
| fetch_words | input | 16 | Buffer word count from the fetched descriptor |
| free_addr | output | 23 | Word address of the next free descriptor slot |
| exhausted | output | 1 | No unread descriptor is available |
| status_valid | output | 1 | Packet status pulse |
| last_pkt | output | 1 | Packet was the last in its area |
| seq_status | output | 16 | {area number, packet number} |

## Verification
The collision that matters most is a counter write arriving in the same cycle as a packet completion. The bench provokes it by driving `reg_wr` with select 1 in the same cycle as `pkt_done`. It then judges two results: the status pulse must report the pre-write numbers, and the following packet must report exactly the written value with no increment on top. A second overlap occurs when a packet's completion and a threshold change are both pending around an area boundary. The bench covers this by reprogramming the threshold while a descriptor is outstanding and checking the next stay-or-move decision against the new value.

// File: rtl/rbaseq_pkg.sv
package rbaseq_pkg;

    typedef enum logic [1:0] {
        ST_NEED_DESC  = 2'd0,
        ST_FETCH_DESC = 2'd1,
        ST_FILL_AREA  = 2'd2
    } area_state_t;

    typedef enum logic [2:0] {
        SEL_THRESH = 3'd0,
        SEL_SEQ    = 3'd1,
        SEL_UPPER  = 3'd2,
        SEL_START  = 3'd3,
        SEL_END    = 3'd4,
        SEL_RDPTR  = 3'd5,
        SEL_WRPTR  = 3'd6
    } reg_sel_t;

    localparam int RING_SLOTS = 4;

endpackage

// File: rtl/rbaseq_cfg.sv
module rbaseq_cfg
    import rbaseq_pkg::*;
#(
    parameter int                 DATA_W     = 16,
    parameter int                 UP_W       = 8,
    parameter logic [DATA_W-1:0]  THRESH_RST = 16'h02F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] thresh,
    output logic [UP_W-1:0]   upper
);

    logic thr_hit;
    logic up_hit;

    assign thr_hit = wr_en && (reg_sel_t'(wr_sel) == SEL_THRESH);
    assign up_hit  = wr_en && (reg_sel_t'(wr_sel) == SEL_UPPER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thresh <= THRESH_RST;
            upper  <= '0;
        end else begin
            if (thr_hit) thresh <= wr_data;
            if (up_hit)  upper  <= wr_data[UP_W-1:0];
        end
    end

    // R1
    thresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_hit |=> $stable(thresh));

endmodule

// File: rtl/rbaseq_ring.sv
module rbaseq_ring
    import rbaseq_pkg::*;
#(
    parameter int IDX_W = 15,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [IDX_W-1:0] wr_idx_data,
    input  logic             adv,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] wr_idx,
    output logic             empty
);

    localparam int               SLOT_START = 0;
    localparam int               SLOT_END   = 1;
    localparam int               SLOT_RD    = 2;
    localparam int               SLOT_WR    = 3;
    localparam logic [IDX_W-1:0] STEP_IDX   = IDX_W'(STEP);

    logic [IDX_W-1:0] ptr_q [RING_SLOTS];
    logic [IDX_W-1:0] rd_sum;
    logic [IDX_W-1:0] rd_next;
    logic             any_wr;

    assign rd_sum  = ptr_q[SLOT_RD] + STEP_IDX;
    assign rd_next = (rd_sum == ptr_q[SLOT_END]) ? ptr_q[SLOT_START] : rd_sum;
    assign any_wr  = wr_en && (wr_sel >= 3'(int'(SEL_START)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RING_SLOTS; i++) ptr_q[i] <= '0;
        end else begin
            for (int i = 0; i < RING_SLOTS; i++) begin
                if (wr_en && (wr_sel == 3'(int'(SEL_START) + i))) begin
                    ptr_q[i] <= wr_idx_data;
                end else if ((i == SLOT_RD) && adv) begin
                    ptr_q[i] <= rd_next;
                end
            end
        end
    end

    assign rd_idx = ptr_q[SLOT_RD];
    assign wr_idx = ptr_q[SLOT_WR];
    assign empty  = (ptr_q[SLOT_RD] == ptr_q[SLOT_WR]);

    // R9
    rd_never_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !any_wr && (ptr_q[SLOT_START] != ptr_q[SLOT_END])) |=> (rd_idx != ptr_q[SLOT_END]));

    // R9
    rd_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !any_wr) |=> $stable(rd_idx));

endmodule

// File: rtl/rbaseq_seqctr.sv
module rbaseq_seqctr
    import rbaseq_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pkt_inc,
    input  logic               area_adv,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [2*SEQ_W-1:0] wr_data,
    output logic [2*SEQ_W-1:0] seq_word
);

    logic [SEQ_W-1:0] pkt_q;
    logic [SEQ_W-1:0] area_q;
    logic             seq_hit;

    assign seq_hit = wr_en && (reg_sel_t'(wr_sel) == SEL_SEQ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_q  <= '0;
            area_q <= '0;
        end else if (seq_hit) begin
            area_q <= wr_data[2*SEQ_W-1:SEQ_W];
            pkt_q  <= wr_data[SEQ_W-1:0];
        end else if (area_adv) begin
            area_q <= area_q + SEQ_W'(1);
            pkt_q  <= '0;
        end else if (pkt_inc) begin
            pkt_q  <= pkt_q + SEQ_W'(1);
        end
    end

    assign seq_word = {area_q, pkt_q};

    // R2
    pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_inc && !area_adv && !seq_hit) |=> (pkt_q == $past(pkt_q) + SEQ_W'(1)) && $stable(area_q));

    // R3
    area_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (area_adv && !seq_hit) |=> (pkt_q == '0) && (area_q == $past(area_q) + SEQ_W'(1)));

    // R6
    seq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_hit |=> (seq_word == $past(wr_data)));

endmodule

// File: rtl/rba_sequencer.sv
module rba_sequencer
    import rbaseq_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               IDX_W      = 15,
    parameter int               UP_W       = 8,
    parameter int               SEQ_W      = 8,
    parameter int               DESC_WORDS = 4,
    parameter logic [CNT_W-1:0] THRESH_RST = 16'h02F8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  pkt_done,
    input  logic [CNT_W-1:0]      pkt_words,
    input  logic                  reg_wr,
    input  logic [2:0]            reg_sel,
    input  logic [CNT_W-1:0]      reg_wdata,
    output logic                  fetch_req,
    output logic [UP_W+IDX_W-1:0] fetch_addr,
    input  logic                  fetch_ack,
    input  logic [CNT_W-1:0]      fetch_words,
    output logic [UP_W+IDX_W-1:0] free_addr,
    output logic                  exhausted,
    output logic                  status_valid,
    output logic                  last_pkt,
    output logic [2*SEQ_W-1:0]    seq_status
);

    area_state_t       state_q;
    area_state_t       state_d;
    logic [CNT_W-1:0]  thresh;
    logic [UP_W-1:0]   upper;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic              ring_empty;
    logic [2*SEQ_W-1:0] seq_word;
    logic [CNT_W-1:0]  remaining_q;
    logic [CNT_W-1:0]  rem_after;
    logic              go_next;
    logic              pkt_take;
    logic              desc_load;

    rbaseq_cfg #(
        .DATA_W     (CNT_W),
        .UP_W       (UP_W),
        .THRESH_RST (THRESH_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .thresh  (thresh),
        .upper   (upper)
    );

    rbaseq_ring #(
        .IDX_W (IDX_W),
        .STEP  (DESC_WORDS)
    ) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wr_sel      (reg_sel),
        .wr_idx_data (reg_wdata[IDX_W:1]),
        .adv         (desc_load),
        .rd_idx      (rd_idx),
        .wr_idx      (wr_idx),
        .empty       (ring_empty)
    );

    rbaseq_seqctr #(
        .SEQ_W (SEQ_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_inc  (pkt_take && !go_next),
        .area_adv (pkt_take && go_next),
        .wr_en    (reg_wr),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata[2*SEQ_W-1:0]),
        .seq_word (seq_word)
    );

    assign pkt_take  = pkt_done && (state_q == ST_FILL_AREA) && !soft_rst;
    assign desc_load = fetch_ack && (state_q == ST_FETCH_DESC) && !soft_rst;
    assign rem_after = (pkt_words >= remaining_q) ? '0 : (remaining_q - pkt_words);
    assign go_next   = (thresh > rem_after);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NEED_DESC;
        else        state_q <= state_d;
    end

    // next state and state outputs
    always_comb begin
        state_d   = state_q;
        fetch_req = 1'b0;
        exhausted = 1'b0;
        unique case (state_q)
            ST_NEED_DESC: begin
                exhausted = ring_empty;
                if (!ring_empty) state_d = ST_FETCH_DESC;
            end
            ST_FETCH_DESC: begin
                fetch_req = 1'b1;
                if (fetch_ack) state_d = ST_FILL_AREA;
            end
            ST_FILL_AREA: begin
                if (pkt_take && go_next) state_d = ST_NEED_DESC;
            end
            default: state_d = ST_NEED_DESC;
        endcase
        if (soft_rst) state_d = ST_NEED_DESC;
    end

    // area budget and packet status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining_q  <= '0;
            status_valid <= 1'b0;
            last_pkt     <= 1'b0;
            seq_status   <= '0;
        end else if (soft_rst) begin
            remaining_q  <= '0;
            status_valid <= 1'b0;
            last_pkt     <= 1'b0;
        end else begin
            status_valid <= pkt_take;
            if (pkt_take) begin
                remaining_q <= rem_after;
                last_pkt    <= go_next;
                seq_status  <= seq_word;
            end else if (desc_load) begin
                remaining_q <= fetch_words;
            end
        end
    end

    assign fetch_addr = {upper, rd_idx};
    assign free_addr  = {upper, wr_idx};

    // R4
    status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> $past(pkt_done));

    // R10
    exhausted_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted |-> !fetch_req);

    // R11
    idle_pkt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && (state_q != ST_FILL_AREA)) |=> !status_valid);

    // R3
    last_leaves_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && last_pkt) |-> (state_q != ST_FILL_AREA));

    // R8
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack && !soft_rst) |=> fetch_req);

    // R7
    soft_to_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state_q == ST_NEED_DESC) && !status_valid);

endmodule

// File: tb/rba_sequencer_tb.sv
`timescale 1ns/1ps
module rba_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        pkt_done = 1'b0;
    logic [15:0] pkt_words = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        fetch_req;
    logic [22:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic [15:0] fetch_words = '0;
    logic [22:0] free_addr;
    logic        exhausted;
    logic        status_valid;
    logic        last_pkt;
    logic [15:0] seq_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model
    logic [15:0] m_thr = 16'h02F8;
    logic [15:0] m_seq = 16'h0000;
    logic [15:0] m_rem = 16'h0000;
    logic [14:0] m_rd  = 15'h0100;
    localparam logic [14:0] M_START = 15'h0100;
    localparam logic [14:0] M_END   = 15'h010C;
    localparam logic [7:0]  M_UP    = 8'h5A;

    always #2.5 clk = ~clk;

    rba_sequencer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .pkt_done     (pkt_done),
        .pkt_words    (pkt_words),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .fetch_ack    (fetch_ack),
        .fetch_words  (fetch_words),
        .free_addr    (free_addr),
        .exhausted    (exhausted),
        .status_valid (status_valid),
        .last_pkt     (last_pkt),
        .seq_status   (seq_status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [15:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel == 3'd0) m_thr = data;
        if (sel == 3'd1) m_seq = data;
    endtask

    task automatic take_desc(input logic [15:0] words, input string req);
        for (int i = 0; i < 16 && !fetch_req; i++) @(negedge clk);
        check(fetch_req == 1'b1, "R8", {31'd0, fetch_req}, 32'd1);
        check(fetch_addr == {M_UP, m_rd}, req, {9'd0, fetch_addr}, {9'd0, M_UP, m_rd});
        fetch_ack = 1'b1; fetch_words = words;
        @(negedge clk);
        fetch_ack = 1'b0;
        m_rem = words;
        m_rd = m_rd + 15'd4;
        if (m_rd == M_END) m_rd = M_START;
    endtask

    task automatic send_pkt(input logic [15:0] words, input string req,
                            input bit with_wr, input logic [15:0] wval);
        logic [15:0] after;
        logic        exp_last;
        after    = (words >= m_rem) ? 16'd0 : (m_rem - words);
        exp_last = (m_thr > after);
        pkt_done = 1'b1; pkt_words = words;
        if (with_wr) begin reg_wr = 1'b1; reg_sel = 3'd1; reg_wdata = wval; end
        @(negedge clk);
        pkt_done = 1'b0; reg_wr = 1'b0;
        check(status_valid == 1'b1, "R4", {31'd0, status_valid}, 32'd1);
        check(seq_status == m_seq, req, {16'd0, seq_status}, {16'd0, m_seq});
        check(last_pkt == exp_last, req, {31'd0, last_pkt}, {31'd0, exp_last});
        m_rem = after;
        if (exp_last) m_seq = {m_seq[15:8] + 8'd1, 8'd0};
        else          m_seq = {m_seq[15:8], m_seq[7:0] + 8'd1};
        if (with_wr)  m_seq = wval;
        @(negedge clk);
        check(status_valid == 1'b0, "R4", {31'd0, status_valid}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status_valid == 1'b0, "R1", {31'd0, status_valid}, 32'd0);
        check(seq_status == 16'h0000, "R1", {16'd0, seq_status}, 32'd0);
        check(exhausted == 1'b1 && fetch_req == 1'b0, "R10", {30'd0, exhausted, fetch_req}, 32'd2);
    endtask

    task automatic t_setup_and_default_thr();
        wr_reg(3'd2, {8'h00, M_UP});
        wr_reg(3'd3, {M_START, 1'b0});
        wr_reg(3'd4, {M_END, 1'b0});
        wr_reg(3'd6, {15'h0108, 1'b1});
        check(free_addr == {M_UP, 15'h0108}, "R13", {9'd0, free_addr}, {9'd0, M_UP, 15'h0108});
        wr_reg(3'd5, {M_START, 1'b0});
        take_desc(16'd761, "R8");
        send_pkt(16'd1, "R1", 1'b0, 16'h0);
        send_pkt(16'd1, "R3", 1'b0, 16'h0);
    endtask

    task automatic t_stay_then_move();
        wr_reg(3'd0, 16'd10);
        take_desc(16'd100, "R9");
        send_pkt(16'd50, "R2", 1'b0, 16'h0);
        send_pkt(16'd45, "R3", 1'b0, 16'h0);
    endtask

    task automatic t_exhaust_and_ignore();
        @(negedge clk);
        check(exhausted == 1'b1 && fetch_req == 1'b0, "R10", {30'd0, exhausted, fetch_req}, 32'd2);
        pkt_done = 1'b1; pkt_words = 16'd3;
        @(negedge clk);
        pkt_done = 1'b0;
        check(status_valid == 1'b0, "R11", {31'd0, status_valid}, 32'd0);
        wr_reg(3'd6, {15'h0104, 1'b0});
        take_desc(16'd5, "R10");
        wr_reg(3'd0, 16'd1);
        send_pkt(16'd200, "R12", 1'b0, 16'h0);
    endtask

    task automatic t_wrap_and_counters();
        take_desc(16'd1000, "R9");
        wr_reg(3'd0, 16'd10);
        wr_reg(3'd1, 16'h12FE);
        send_pkt(16'd1, "R5", 1'b0, 16'h0);
        send_pkt(16'd1, "R5", 1'b0, 16'h0);
        send_pkt(16'd1, "R5", 1'b0, 16'h0);
        send_pkt(16'd1, "R6", 1'b1, 16'h3344);
        send_pkt(16'd1, "R6", 1'b0, 16'h0);
        wr_reg(3'd1, 16'h0000);
        send_pkt(16'd1, "R6", 1'b0, 16'h0);
    endtask

    task automatic t_soft_reset();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(exhausted == 1'b1, "R7", {31'd0, exhausted}, 32'd1);
        wr_reg(3'd6, {15'h0400, 1'b0});
        take_desc(16'd20, "R7");
        send_pkt(16'd5, "R7", 1'b0, 16'h0);
        send_pkt(16'd6, "R7", 1'b0, 16'h0);
    endtask

    task automatic t_area_wrap();
        wr_reg(3'd1, 16'hFF07);
        take_desc(16'd20, "R9");
        send_pkt(16'd15, "R5", 1'b0, 16'h0);
        take_desc(16'd50, "R9");
        send_pkt(16'd1, "R5", 1'b0, 16'h0);
    endtask

    initial begin
        t_reset();
        t_setup_and_default_thr();
        t_stay_then_move();
        t_exhaust_and_ignore();
        t_wrap_and_counters();
        t_soft_reset();
        t_area_wrap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule